// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits in the write path of a byte-wide non-volatile memory, in front of the page buffer. Every write request carries a 16-bit address and a byte of data. For each write the block makes one of three decisions in the same cycle. The write may be a command byte, which is swallowed. It may be a data write, which is passed on to the array. Otherwise it is a blocked write, which is dropped.

Two fixed key sequences are recognised. The arming sequence sets the persistent protection flag and opens a window for exactly one page load. The window closes when the page controller reports the end of the load, or when the page byte limit is reached. Protection is then back in force. The disarming sequence starts a programming-time wait, after which the block returns to open mode. The protection flag lives in non-volatile state. A power-cycle pulse therefore keeps the flag but discards everything that is only in progress.

Top module: `wp_seq_guard`

## Requirements
- R1: The arming sequence is three writes in order: data 0xAA at key address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Each of the three writes gives `wr_cmd`=1 and `wr_allow`=0. From the cycle after the third write, `prot_on`=1 and `win_open`=1.
- R2: While `win_open`=1, every write gives `wr_allow`=1 and `wr_cmd`=0, even if it matches a key. The PAGE_BYTES-th such write (default 128) closes the window, and later non-command writes are blocked.
- R3: A cycle with `page_done`=1 while the window is open closes it from the next cycle. After that, non-command writes are blocked while `prot_on`=1.
- R4: The disarming sequence is six writes in order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. All six are suppressed. From the next cycle, `busy`=1 for PROG_CYCLES cycles (default 64). During that time every write gives `wr_allow`=0 and `wr_cmd`=0. After it, `busy`=0 and `prot_on`=0.
- R5: While `prot_on`=0 and `busy`=0, every write that is not a command byte gives `wr_allow`=1.
- R6: Address bit 15 is ignored when keys are compared. Only bits 14..0 must match.
- R7: A write that does not continue a partly matched sequence aborts the match. If that write is itself 0xAA@0x5555, it starts a new match and is suppressed. Otherwise it is an ordinary write: blocked when protected with the window closed, passed when unprotected.
- R8: `pwr_cycle`=1 keeps `prot_on` unchanged. It closes the window, clears any partial match and cancels a pending disarm wait. A write presented in the same cycle is ignored (`wr_allow`=0, `wr_cmd`=0).
- R9: After reset, `prot_on`=0, `win_open`=0 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (initial state of the non-volatile flag) |
| wr_valid | input | 1 | A write request is present this cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data byte |
| page_done | input | 1 | Page controller reports the end of the granted page load |
| pwr_cycle | input | 1 | Power-down/power-up pulse |
| wr_allow | output | 1 | Pass this write to the array |
| wr_cmd | output | 1 | This write is a command byte and is suppressed |
| prot_on | output | 1 | Protection flag |
| win_open | output | 1 | One-page write window is open |
| busy | output | 1 | Disarm programming wait in progress |

## Verification
The key matcher is driven with the complete arming and disarming sequences, with bit 15 both set and clear. It is also driven with sequences cut off at every step, with a break byte that is itself the first key, and with a power pulse in the middle of a match. These cases tell apart a matcher that restarts correctly from one that sticks or over-matches. Page loads are ended both by `page_done` and by the byte limit, which separates the two close paths. Random traffic is biased towards key addresses and key data, and is run in both protected and open modes. It is compared against a bench model that tracks its position in the disarm key list.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  localparam int KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_D_LEAD   = 8'hAA;
  localparam logic [7:0] KEY_D_SECOND = 8'h55;
  localparam logic [7:0] KEY_D_ARM    = 8'hA0;
  localparam logic [7:0] KEY_D_PREDIS = 8'h80;
  localparam logic [7:0] KEY_D_DISARM = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_PAIR = 3'd2,
    ST_PRE  = 3'd3,
    ST_RELEAD = 3'd4,
    ST_REPAIR = 3'd5
  } step_t;

  typedef struct packed {
    logic  hit;
    logic  arm;
    logic  disarm;
    step_t nxt;
  } step_res_t;

  function automatic logic key_is(input logic [KEY_W-1:0] a, input logic [7:0] d,
                                  input logic [KEY_W-1:0] ka, input logic [7:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  function automatic step_res_t step_after(input step_t s, input logic [KEY_W-1:0] a,
                                           input logic [7:0] d);
    step_res_t r;
    logic lead;
    lead = key_is(a, d, KEY_ADDR_A, KEY_D_LEAD);
    r = '{hit: lead, arm: 1'b0, disarm: 1'b0, nxt: (lead ? ST_LEAD : ST_IDLE)};
    case (s)
      ST_LEAD: if (key_is(a, d, KEY_ADDR_B, KEY_D_SECOND)) begin
        r.hit = 1'b1; r.nxt = ST_PAIR;
      end
      ST_PAIR: if (key_is(a, d, KEY_ADDR_A, KEY_D_ARM)) begin
        r.hit = 1'b1; r.arm = 1'b1; r.nxt = ST_IDLE;
      end else if (key_is(a, d, KEY_ADDR_A, KEY_D_PREDIS)) begin
        r.hit = 1'b1; r.nxt = ST_PRE;
      end
      ST_PRE: if (lead) begin
        r.hit = 1'b1; r.nxt = ST_RELEAD;
      end
      ST_RELEAD: if (key_is(a, d, KEY_ADDR_B, KEY_D_SECOND)) begin
        r.hit = 1'b1; r.nxt = ST_REPAIR;
      end
      ST_REPAIR: if (key_is(a, d, KEY_ADDR_A, KEY_D_DISARM)) begin
        r.hit = 1'b1; r.disarm = 1'b1; r.nxt = ST_IDLE;
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wpg_seq_match.sv
module wpg_seq_match
  import wpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_eff,
  input  logic             hold,
  input  logic             pwr_cycle,
  input  logic [KEY_W-1:0] key_addr,
  input  logic [7:0]       key_data,
  output logic             hit,
  output logic             arm_done,
  output logic             disarm_done
);

  step_t     step_q;
  step_res_t res;
  logic      look;

  assign res  = step_after(step_q, key_addr, key_data);
  assign look = wr_eff && !hold;

  assign hit         = look && res.hit;
  assign arm_done    = look && res.arm;
  assign disarm_done = look && res.disarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        step_q <= ST_IDLE;
    else if (pwr_cycle) step_q <= ST_IDLE;
    else if (hold)     step_q <= ST_IDLE;
    else if (look)     step_q <= res.nxt;
  end

  AST_PWR_CLEARS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> (step_q == ST_IDLE)); // R8
  AST_DISARM_AFTER_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_done |-> (step_q == ST_REPAIR)); // R4
  AST_ARM_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    arm_done |-> (step_q == ST_PAIR)); // R1

endmodule

// File: rtl/wpg_prot_state.sv
module wpg_prot_state #(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_cycle,
  input  logic arm_done,
  input  logic disarm_done,
  output logic prot_on,
  output logic busy
);

  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic          prot_q, busy_q;
  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      busy_q <= 1'b0;
      wait_q <= '0;
    end else if (pwr_cycle) begin
      busy_q <= 1'b0;
      wait_q <= '0;
    end else if (arm_done) begin
      prot_q <= 1'b1;
    end else if (disarm_done) begin
      busy_q <= 1'b1;
      wait_q <= LOAD;
    end else if (busy_q) begin
      if (wait_q == '0) begin
        busy_q <= 1'b0;
        prot_q <= 1'b0;
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign prot_on = prot_q;
  assign busy    = busy_q;

  AST_PROT_DROPS_ONLY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_q) |-> $past(busy_q)); // R4
  AST_ARM_SETS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_done && !pwr_cycle) |=> prot_q); // R1

endmodule

// File: rtl/wpg_page_window.sv
module wpg_page_window #(
  parameter int PAGE_BYTES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_cycle,
  input  logic open_req,
  input  logic page_done,
  input  logic data_wr,
  output logic win_open
);

  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(PAGE_BYTES - 1);

  logic          win_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      cnt_q <= '0;
    end else if (pwr_cycle) begin
      win_q <= 1'b0;
      cnt_q <= '0;
    end else if (open_req) begin
      win_q <= 1'b1;
      cnt_q <= '0;
    end else if (win_q) begin
      if (page_done || (data_wr && cnt_q == LAST)) begin
        win_q <= 1'b0;
        cnt_q <= '0;
      end else if (data_wr) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign win_open = win_q;

  AST_WIN_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
  AST_PAGE_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && page_done && !open_req) |=> !win_q); // R3

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              page_done,
  input  logic              pwr_cycle,
  output logic              wr_allow,
  output logic              wr_cmd,
  output logic              prot_on,
  output logic              win_open,
  output logic              busy
);

  logic wr_eff, hold, hit, arm_done, disarm_done, data_wr;
  logic unused_hi;

  assign unused_hi = ^wr_addr[ADDR_W-1:KEY_W];
  assign wr_eff    = wr_valid && !pwr_cycle;
  assign hold      = win_open || busy;

  wpg_seq_match u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_eff      (wr_eff),
    .hold        (hold),
    .pwr_cycle   (pwr_cycle),
    .key_addr    (wr_addr[KEY_W-1:0]),
    .key_data    (wr_data),
    .hit         (hit),
    .arm_done    (arm_done),
    .disarm_done (disarm_done)
  );

  wpg_prot_state #(.PROG_CYCLES(PROG_CYCLES)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_cycle   (pwr_cycle),
    .arm_done    (arm_done),
    .disarm_done (disarm_done),
    .prot_on     (prot_on),
    .busy        (busy)
  );

  assign wr_cmd   = hit;
  assign wr_allow = wr_eff && !hit && !busy && (!prot_on || win_open);
  assign data_wr  = wr_eff && win_open;

  wpg_page_window #(.PAGE_BYTES(PAGE_BYTES)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_cycle (pwr_cycle),
    .open_req  (arm_done),
    .page_done (page_done),
    .data_wr   (data_wr),
    .win_open  (win_open)
  );

  AST_LOCKED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_on && !win_open) |-> !wr_allow); // R7
  AST_PWR_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> (prot_on == $past(prot_on))); // R8
  AST_ARM_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_done && !pwr_cycle) |=> (win_open && prot_on)); // R1
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wr_allow && !wr_cmd)); // R4

endmodule

// File: tb/test_wp_seq_guard.sv
module test_wp_seq_guard;

  localparam int PAGE = 128;
  localparam int PROG = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic page_done = 1'b0;
  logic pwr_cycle = 1'b0;
  logic wr_allow, wr_cmd, prot_on, win_open, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wp_seq_guard i_wp_seq_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .page_done(page_done), .pwr_cycle(pwr_cycle),
    .wr_allow(wr_allow), .wr_cmd(wr_cmd), .prot_on(prot_on),
    .win_open(win_open), .busy(busy)
  );

  // bench model: position in the six-entry disarm key list
  logic [14:0] ka [6] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555};
  logic [7:0]  kd [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
  int m_pos = 0, m_wcnt = 0, m_bcnt = 0;
  bit m_prot = 0, m_win = 0, m_busy = 0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, "prot_on", prot_on, m_prot);
    chk(req, "win_open", win_open, m_win);
    chk(req, "busy", busy, m_busy);
  endtask

  // classify a key pair against the model position
  function automatic void predict(input int pos, input logic [14:0] a, input logic [7:0] d,
                                  output bit h, output int np, output bit en, output bit dis);
    h = 0; np = 0; en = 0; dis = 0;
    if (pos == 2 && a == 15'h5555 && d == 8'hA0) begin
      h = 1; en = 1; np = 0;
    end else if (pos > 0 && a == ka[pos] && d == kd[pos]) begin
      h = 1; np = pos + 1;
      if (pos == 5) begin dis = 1; np = 0; end
    end else if (a == 15'h5555 && d == 8'hAA) begin
      h = 1; np = 1;
    end
  endfunction

  task automatic cyc(input logic v, input logic [15:0] a, input logic [7:0] d,
                     input logic pd, input logic pc, input string req);
    bit h, en, dis, eff, hold, e_cmd, e_allow;
    int np;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; page_done = pd; pwr_cycle = pc;
    #5;
    predict(m_pos, a[14:0], d, h, np, en, dis);
    eff = v && !pc;
    hold = m_win || m_busy;
    e_cmd = eff && !hold && h;
    e_allow = eff && !e_cmd && !m_busy && (!m_prot || m_win);
    chk(req, "wr_cmd", wr_cmd, e_cmd);
    chk(req, "wr_allow", wr_allow, e_allow);
    @(posedge clk);
    #2;
    if (pc) begin
      m_pos = 0; m_win = 0; m_wcnt = 0; m_busy = 0;
    end else begin
      if (m_busy) begin
        m_bcnt--;
        if (m_bcnt == 0) begin m_busy = 0; m_prot = 0; end
      end else if (m_win) begin
        m_pos = 0;
        if (pd) begin m_win = 0; m_wcnt = 0; end
        else if (v) begin
          m_wcnt++;
          if (m_wcnt == PAGE) begin m_win = 0; m_wcnt = 0; end
        end
      end else if (v) begin
        m_pos = np;
        if (en) begin m_prot = 1; m_win = 1; m_wcnt = 0; end
        if (dis) begin m_busy = 1; m_bcnt = PROG; end
      end
    end
    chk_state(req);
    wr_valid = 0; page_done = 0; pwr_cycle = 0;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, req);
  endtask

  task automatic arm(input logic hi, input string req);
    cyc(1'b1, {hi, 15'h5555}, 8'hAA, 1'b0, 1'b0, req);
    cyc(1'b1, {hi, 15'h2AAA}, 8'h55, 1'b0, 1'b0, req);
    cyc(1'b1, {hi, 15'h5555}, 8'hA0, 1'b0, 1'b0, req);
  endtask

  task automatic disarm(input logic hi, input int upto, input string req);
    for (int i = 0; i < upto; i++) cyc(1'b1, {hi, ka[i]}, kd[i], 1'b0, 1'b0, req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #35;
    chk_state("R9");
    rst_n = 1'b1;
    idle(2, "R9");

    // R5: open mode passes ordinary writes
    for (int i = 0; i < 8; i++) cyc(1'b1, 16'(i * 4099), 8'(i * 37), 1'b0, 1'b0, "R5");
    // R7: broken prefix in open mode; the breaking byte passes
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, 1'b0, "R7");
    cyc(1'b1, 16'h1234, 8'h12, 1'b0, 1'b0, "R7");
    // R7: restart on lead key
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, 1'b0, "R7");
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, 1'b0, "R7");
    cyc(1'b1, 16'h2AAA, 8'h55, 1'b0, 1'b0, "R7");
    cyc(1'b1, 16'h0001, 8'h01, 1'b0, 1'b0, "R7");

    // R1 + R2: arm then fill the page to its limit
    arm(1'b0, "R1");
    for (int i = 0; i < PAGE; i++) cyc(1'b1, 16'h0300 + 16'(i), 8'(i), 1'b0, 1'b0, "R2");
    cyc(1'b1, 16'h0400, 8'h77, 1'b0, 1'b0, "R2");
    // keys inside a window count as data
    arm(1'b0, "R1");
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, 1'b0, "R2");
    // R3: page_done ends the window
    cyc(1'b1, 16'h0101, 8'h01, 1'b1, 1'b0, "R3");
    cyc(1'b1, 16'h0102, 8'h02, 1'b0, 1'b0, "R3");
    // R6: arming with bit 15 set
    arm(1'b1, "R6");
    cyc(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, "R6");
    // R7: protected, broken sequence blocked
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, 1'b0, "R7");
    cyc(1'b1, 16'h2AAB, 8'h55, 1'b0, 1'b0, "R7");
    // R8: power pulse mid-sequence
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, 1'b0, "R8");
    cyc(1'b1, 16'h2AAA, 8'h55, 1'b0, 1'b0, "R8");
    cyc(1'b1, 16'h0000, 8'h00, 1'b0, 1'b1, "R8");
    cyc(1'b1, 16'h5555, 8'hA0, 1'b0, 1'b0, "R8");
    // R8: power pulse cancels pending disarm
    disarm(1'b1, 6, "R4");
    idle(5, "R4");
    cyc(1'b0, 16'h0, 8'h0, 1'b0, 1'b1, "R8");
    idle(PROG, "R8");
    // R4: full disarm with writes during the wait
    disarm(1'b0, 6, "R4");
    for (int i = 0; i < PROG; i++) cyc(1'b1, 16'h5555, 8'hAA, 1'b0, 1'b0, "R4");
    cyc(1'b1, 16'h0042, 8'h42, 1'b0, 1'b0, "R4");

    // random traffic biased towards keys
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [15:0] a;
      logic [7:0] d;
      k = int'($urandom_range(0, 9));
      if (k < 6) begin
        a = {1'($urandom), ka[k]};
        d = kd[k];
        if (k == 2 && $urandom_range(0, 1) == 0) d = 8'hA0;
      end else begin
        a = 16'($urandom);
        d = 8'($urandom);
      end
      cyc(1'($urandom_range(0, 7) != 0), a, d, ($urandom_range(0, 39) == 0),
          ($urandom_range(0, 199) == 0), "R7");
    end
    finish_run();
  end

endmodule